// File: doc/BRIEF.md
# Frame-Synchronous Timeslot Serial Port

This block joins a shared, frame-synchronous serial line with one 32-bit timeslot per frame. A frame sync pulse arrives every 125 µs. A continuous data clock runs at twice the bit rate, so each bit lasts two data-clock cycles. A 3-bit select register chooses which of eight timeslots the block owns. During that slot the block shifts out a parallel transmit word, MSB first, on an open-drain style output. In the same slot it assembles the word arriving on the serial input. The selected slot carries all of the slot's bits, including any monitor or command/indication bits, and they pass through unchanged. Outside the slot the output is released, so other devices can pull the shared line low.

The data clock may run at any multiple of 16 kHz from 512 to 4096 kHz. The block therefore counts data-clock cycles between frame syncs to find how many bits the frame holds. It raises a flag when the selected slot does not fit. While the flag is set the block neither drives the line nor captures data. The data clock, frame sync and serial input are sampled in the system clock domain. Each data-clock level must last at least three system clocks.

Received words leave as a stream with a valid strobe and no ready. There is no back-pressure: the consumer must take each word in the single cycle its strobe is high. The word stays on the data pins until the next one replaces it. The transmit word is a plain parallel input, sampled once per frame.

Top module: `gci_slot_port`

## Requirements
- R1: After reset the output enable is 0, the output data is 1, rx_valid is 0, rx_data is 0 and slot_invalid is 1. The select register resets to timeslot 0.
- R2: sel_i is a 3-bit binary slot number (0 to 7), written when sel_wr_i is high. A write takes effect at the next frame sync and not before.
- R3: A frame sync is a data-clock rising edge with fsc_i high after one with fsc_i low. That edge is data-clock cycle 0. Cycles 2n and 2n+1 form bit n. Outputs follow two system clocks after the data-clock rise, and slot_invalid follows one system clock after it.
- R4: Slot S covers bits 32S to 32S+31. For each of these bits, the output is enabled on the bit's first cycle and carries bit 31-k of the latched word, where k is the bit's offset in the slot. The word therefore goes out MSB first.
- R5: din_i is sampled on the second cycle of each bit in the slot. The first sample becomes bit 31 of the received word.
- R6: After the last bit of the slot is sampled, rx_valid is high for exactly one system clock. rx_data carries the new word in that cycle and keeps its value until the next word.
- R7: tx_word_i is latched at each frame sync. A change in the middle of a frame has no effect on the bits sent in that frame.
- R8: slot_invalid is 1 when 32×(slot+1) is greater than half the number of data-clock cycles in the previous frame. It stays 1 until two frame syncs have been seen.
- R9: While slot_invalid is 1, the output is not enabled and no word is captured.
- R10: Outside the slot, the output enable is 0 and the data output is 1, so an undriven line reads as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcl_i | input | 1 | Data clock, two cycles per bit |
| fsc_i | input | 1 | 8 kHz frame sync |
| din_i | input | 1 | Serial receive line |
| sel_wr_i | input | 1 | Write strobe for the slot select register |
| sel_i | input | 3 | Slot number to write |
| tx_word_i | input | 32 | Word to send in the owned slot |
| bus_oe_o | output | 1 | Drive enable for the shared line (low driven when data is 0) |
| bus_data_o | output | 1 | Bit presented to the line, 1 when released |
| rx_valid_o | output | 1 | One-cycle strobe for a received word |
| rx_data_o | output | 32 | Received word, MSB first on the line |
| slot_invalid_o | output | 1 | Selected slot does not fit the measured frame |

## Verification
Two sets of events can fall on the same data-clock edge. The first is the frame-sync edge. On that edge the frame length is re-measured, the pending slot number and a new transmit word are loaded, and, with slot 0 selected, the first bit is launched using the word that was just latched. The bench provokes this by changing tx_word_i and the slot select between frames, and by moving between frame lengths in which a slot goes from fitting to not fitting. A reference model, stepped on the same edges, decides which word must appear and whether the line may be driven. The second coincidence occurs when slot 7 ends at the last bit of a full frame: the capture strobe lands next to the following frame sync, and the model checks that strobe and word in exactly the cycles it predicts.

// File: rtl/gci_slot_pkg.sv
package gci_slot_pkg;
  // Half of a bit period: launch on the first data-clock cycle, sample on the second.
  typedef enum logic {
    PH_LAUNCH  = 1'b0,
    PH_CAPTURE = 1'b1
  } bit_phase_e;
endpackage

// File: rtl/gci_frame_timer.sv
module gci_frame_timer #(
  parameter int CYC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dcl_i,
  input  logic             fsc_i,
  output logic             fs_tick_o,
  output logic             step_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic [CYC_W-1:0] meas_o
);
  localparam logic [CYC_W-1:0] CYC_MAX = '1;

  logic             dcl_q;
  logic             fsc_prev;
  logic             synced;
  logic             step_q;
  logic             tick;
  logic [CYC_W-1:0] cyc_q;
  logic [CYC_W-1:0] meas_q;

  assign tick      = dcl_i & ~dcl_q;
  assign fs_tick_o = tick & fsc_i & ~fsc_prev;
  assign step_o    = step_q;
  assign cyc_o     = cyc_q;
  assign meas_o    = meas_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcl_q    <= 1'b0;
      fsc_prev <= 1'b0;
      synced   <= 1'b0;
      step_q   <= 1'b0;
      cyc_q    <= '0;
      meas_q   <= '0;
    end else begin
      dcl_q  <= dcl_i;
      step_q <= tick;
      if (tick) begin
        fsc_prev <= fsc_i;
        if (fs_tick_o) begin
          cyc_q  <= '0;
          synced <= 1'b1;
          if (!synced)
            meas_q <= '0;
          else if (cyc_q == CYC_MAX)
            meas_q <= CYC_MAX;
          else
            meas_q <= cyc_q + CYC_W'(1);
        end else if (cyc_q != CYC_MAX) begin
          cyc_q <= cyc_q + CYC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/gci_slot_window.sv
module gci_slot_window #(
  parameter int SEL_W     = 3,
  parameter int SLOT_BITS = 32,
  parameter int CYC_W     = 10,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             fs_tick_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic [CYC_W-1:0] meas_i,
  output logic             invalid_o,
  output logic             in_win_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int NW = CYC_W + SEL_W + 1;

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] act_q;
  logic [NW-1:0]    lo;
  logic [NW-1:0]    hi;
  logic [NW-1:0]    bits_in_frame;
  logic [NW-1:0]    bit_pos;
  logic [NW-1:0]    offs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      act_q <= '0;
    end else begin
      if (sel_wr_i)
        sel_q <= sel_i;
      if (fs_tick_i)
        act_q <= sel_q;
    end
  end

  always_comb begin
    lo            = NW'(act_q) * NW'(SLOT_BITS);
    hi            = lo + NW'(SLOT_BITS);
    bits_in_frame = NW'(meas_i >> 1);
    bit_pos       = NW'(cyc_i >> 1);
    offs          = bit_pos - lo;
    invalid_o     = (hi > bits_in_frame);
    in_win_o      = !invalid_o && (bit_pos >= lo) && (bit_pos < hi);
    idx_o         = offs[IDX_W-1:0];
  end
endmodule

// File: rtl/gci_slot_shifter.sv
module gci_slot_shifter
  import gci_slot_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int IDX_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fs_tick_i,
  input  logic                 step_i,
  input  bit_phase_e           phase_i,
  input  logic                 in_win_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [SLOT_BITS-1:0] tx_word_i,
  input  logic                 din_i,
  output logic                 bus_oe_o,
  output logic                 bus_data_o,
  output logic                 rx_valid_o,
  output logic [SLOT_BITS-1:0] rx_data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_BITS - 1);

  logic [SLOT_BITS-1:0] tx_lat;
  logic [SLOT_BITS-1:0] rx_sh;
  logic [SLOT_BITS-1:0] rx_next;

  assign rx_next = {rx_sh[SLOT_BITS-2:0], din_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_lat     <= '0;
      rx_sh      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      bus_oe_o   <= 1'b0;
      bus_data_o <= 1'b1;
    end else begin
      rx_valid_o <= 1'b0;
      if (fs_tick_i)
        tx_lat <= tx_word_i;
      if (step_i) begin
        if (phase_i == PH_LAUNCH) begin
          bus_oe_o   <= in_win_i;
          bus_data_o <= in_win_i ? tx_lat[LAST_IDX - idx_i] : 1'b1;
        end else if (in_win_i) begin
          rx_sh <= rx_next;
          if (idx_i == LAST_IDX) begin
            rx_data_o  <= rx_next;
            rx_valid_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/gci_slot_port.sv
module gci_slot_port
  import gci_slot_pkg::*;
#(
  parameter int NUM_SLOTS     = 8,
  parameter int SLOT_BITS     = 32,
  parameter int MAX_FRAME_CYC = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         dcl_i,
  input  logic                         fsc_i,
  input  logic                         din_i,
  input  logic                         sel_wr_i,
  input  logic [$clog2(NUM_SLOTS)-1:0] sel_i,
  input  logic [SLOT_BITS-1:0]         tx_word_i,
  output logic                         bus_oe_o,
  output logic                         bus_data_o,
  output logic                         rx_valid_o,
  output logic [SLOT_BITS-1:0]         rx_data_o,
  output logic                         slot_invalid_o
);
  localparam int SEL_W = $clog2(NUM_SLOTS);
  localparam int IDX_W = $clog2(SLOT_BITS);
  localparam int CYC_W = $clog2(MAX_FRAME_CYC + 1);

  logic             fs_tick;
  logic             step;
  logic [CYC_W-1:0] cyc;
  logic [CYC_W-1:0] meas;
  logic             in_win;
  logic [IDX_W-1:0] idx;
  bit_phase_e       phase;

  assign phase = bit_phase_e'(cyc[0]);

  gci_frame_timer #(.CYC_W(CYC_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .dcl_i    (dcl_i),
    .fsc_i    (fsc_i),
    .fs_tick_o(fs_tick),
    .step_o   (step),
    .cyc_o    (cyc),
    .meas_o   (meas)
  );

  gci_slot_window #(
    .SEL_W    (SEL_W),
    .SLOT_BITS(SLOT_BITS),
    .CYC_W    (CYC_W),
    .IDX_W    (IDX_W)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_wr_i (sel_wr_i),
    .sel_i    (sel_i),
    .fs_tick_i(fs_tick),
    .cyc_i    (cyc),
    .meas_i   (meas),
    .invalid_o(slot_invalid_o),
    .in_win_o (in_win),
    .idx_o    (idx)
  );

  gci_slot_shifter #(
    .SLOT_BITS(SLOT_BITS),
    .IDX_W    (IDX_W)
  ) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_tick_i (fs_tick),
    .step_i    (step),
    .phase_i   (phase),
    .in_win_i  (in_win),
    .idx_i     (idx),
    .tx_word_i (tx_word_i),
    .din_i     (din_i),
    .bus_oe_o  (bus_oe_o),
    .bus_data_o(bus_data_o),
    .rx_valid_o(rx_valid_o),
    .rx_data_o (rx_data_o)
  );
endmodule

// File: rtl/gci_slot_port_chk.sv
module gci_slot_port_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dcl_i,
  input logic          bus_oe_o,
  input logic          bus_data_o,
  input logic          rx_valid_o,
  input logic [DW-1:0] rx_data_o,
  input logic          slot_invalid_o
);
  // R10: a released line shows 1
  p_release_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> bus_data_o);

  // R9: a flag that has been set for more than one cycle keeps the line free
  p_no_drive_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_invalid_o && $past(slot_invalid_o) |-> !bus_oe_o);

  // R6: the strobe lasts exactly one cycle
  p_rx_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R6: the word holds between strobes
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> $stable(rx_data_o));

  // R9: no word is delivered from a slot flagged as not fitting
  p_rx_only_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> !slot_invalid_o);

  // R4: the drive enable moves only in the high phase of the data clock
  p_oe_on_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_oe_o) |-> dcl_i);
endmodule

bind gci_slot_port gci_slot_port_chk #(.DW(SLOT_BITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dcl_i         (dcl_i),
  .bus_oe_o      (bus_oe_o),
  .bus_data_o    (bus_data_o),
  .rx_valid_o    (rx_valid_o),
  .rx_data_o     (rx_data_o),
  .slot_invalid_o(slot_invalid_o)
);

// File: tb/tb_gci_slot_port.sv
module tb_gci_slot_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dcl = 1'b0;
  logic        fsc = 1'b0;
  logic        din = 1'b0;
  logic        sel_wr = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [31:0] tx_word = 32'h0;
  logic        bus_oe;
  logic        bus_data;
  logic        rx_valid;
  logic [31:0] rx_data;
  logic        slot_invalid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gci_slot_port dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .dcl_i         (dcl),
    .fsc_i         (fsc),
    .din_i         (din),
    .sel_wr_i      (sel_wr),
    .sel_i         (sel),
    .tx_word_i     (tx_word),
    .bus_oe_o      (bus_oe),
    .bus_data_o    (bus_data),
    .rx_valid_o    (rx_valid),
    .rx_data_o     (rx_data),
    .slot_invalid_o(slot_invalid)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1 reset";

  // expected port values
  logic        exp_oe = 1'b0, exp_data = 1'b1, exp_rxv = 1'b0, exp_inv = 1'b1;
  logic [31:0] exp_rxd = 32'h0;

  // reference model state
  int          m_cyc = 0, m_meas = 0, m_act = 0, m_sel = 0;
  bit          m_synced = 0, m_fsc_prev = 0;
  logic [31:0] m_tx = 32'h0, m_rx = 32'h0;
  logic [31:0] lfsr = 32'hACE1_1234;

  task automatic fail(input string req, input string nm, input logic [31:0] act, input logic [31:0] ex);
    errors++;
    $display("FAIL %s [%s] %s actual=%h expected=%h", phase, req, nm, act, ex);
  endtask

  task automatic chk();
    string rb;
    @(negedge clk);
    rb = exp_inv ? "R9" : (exp_oe ? "R4" : "R10");
    checks += 5;
    if (bus_oe !== exp_oe)         fail(rb, "bus_oe", 32'(bus_oe), 32'(exp_oe));
    if (bus_data !== exp_data)     fail(rb, "bus_data", 32'(bus_data), 32'(exp_data));
    if (rx_valid !== exp_rxv)      fail("R6", "rx_valid", 32'(rx_valid), 32'(exp_rxv));
    if (rx_data !== exp_rxd)       fail("R5", "rx_data", rx_data, exp_rxd);
    if (slot_invalid !== exp_inv)  fail("R8", "slot_invalid", 32'(slot_invalid), 32'(exp_inv));
  endtask

  // One data-clock cycle: rise, model step, outputs checked on every system clock (R3 timing).
  task automatic dcl_cycle(input bit fsc_v);
    bit p_oe, p_data, p_rxv, inw, fstart;
    logic [31:0] p_rxd;
    int b, lo, k;
    chk();
    din  = lfsr[0];
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    dcl  = 1'b1;
    fsc  = fsc_v;
    fstart = fsc_v && !m_fsc_prev;
    m_fsc_prev = fsc_v;
    if (fstart) begin
      m_meas   = m_synced ? ((m_cyc == 1023) ? 1023 : m_cyc + 1) : 0;
      m_synced = 1;
      m_cyc    = 0;
      m_act    = m_sel;
      m_tx     = tx_word;
    end else if (m_cyc < 1023) begin
      m_cyc++;
    end
    exp_inv = ((m_act + 1) * 32 > m_meas / 2);
    b   = m_cyc / 2;
    lo  = m_act * 32;
    inw = !exp_inv && b >= lo && b < lo + 32;
    k   = b - lo;
    p_oe = exp_oe; p_data = exp_data; p_rxv = 1'b0; p_rxd = exp_rxd;
    if (m_cyc % 2 == 0) begin
      p_oe   = inw;
      p_data = inw ? m_tx[31 - k] : 1'b1;
    end else if (inw) begin
      m_rx = {m_rx[30:0], din};
      if (k == 31) begin
        p_rxv = 1'b1;
        p_rxd = m_rx;
      end
    end
    chk();
    exp_oe = p_oe; exp_data = p_data;
    if (p_rxv) begin exp_rxv = 1'b1; exp_rxd = p_rxd; end
    chk();
    exp_rxv = 1'b0;
    chk();
    dcl = 1'b0;
    chk(); chk(); chk();
  endtask

  task automatic write_sel(input int v);
    chk();
    sel_wr = 1'b1;
    sel    = 3'(v);
    chk();
    sel_wr = 1'b0;
    m_sel  = v;
  endtask

  // A frame of n data-clock cycles; optional select write and tx change halfway (R2, R7).
  task automatic run_frame(input int n, input bit do_sel, input int nsel,
                           input bit do_tx, input logic [31:0] ntx);
    for (int c = 0; c < n; c++) begin
      if (c == n / 2) begin
        if (do_sel) write_sel(nsel);
        if (do_tx) tx_word = ntx;
      end
      dcl_cycle(c == 0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset values, both during and right after reset
    chk(); chk();
    @(negedge clk);
    rst_n = 1'b1;
    chk(); chk();

    phase = "R3 counting before first sync";
    for (int i = 0; i < 20; i++) dcl_cycle(1'b0);

    phase = "R8 first frame unmeasured";
    tx_word = 32'hA5C3_0F96;
    run_frame(512, 0, 0, 0, 0);
    phase = "R4 R5 slot 0 at full rate";
    run_frame(512, 0, 0, 0, 0);
    phase = "R7 new word at sync, mid-frame change ignored, R2 select 7 pending";
    tx_word = 32'h3C5A_F00F;
    run_frame(512, 1, 7, 1, 32'h0123_4567);
    phase = "R2 slot 7 active, ends at last bit of frame";
    run_frame(512, 0, 0, 0, 0);
    phase = "R7 slot 7 with new word";
    tx_word = 32'hFFFF_0000;
    run_frame(512, 1, 3, 0, 0);

    phase = "R8 slow frame with fast measurement";
    run_frame(256, 0, 0, 0, 0);
    phase = "R4 slot 3 at half rate";
    tx_word = 32'h8000_0001;
    run_frame(256, 1, 4, 0, 0);
    phase = "R9 slot 4 does not fit";
    run_frame(256, 1, 1, 0, 0);
    phase = "R5 slot 1 at quarter rate";
    tx_word = 32'h0F0F_F0F0;
    run_frame(128, 0, 0, 0, 0);
    phase = "R8 slot 1 fits exactly";
    run_frame(128, 1, 2, 0, 0);
    phase = "R9 slot 2 overflows quarter rate";
    run_frame(128, 0, 0, 0, 0);
    phase = "R8 recovery after rate rise";
    tx_word = 32'h5555_AAAA;
    run_frame(512, 0, 0, 0, 0);
    phase = "R10 slot 2 at full rate";
    run_frame(512, 0, 0, 0, 0);
    dcl_cycle(1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule